// File: doc/BRIEF.md
# Mode-Selectable Fractional Multiplier Stage

This block is the multiply and product-register stage of a 16-bit DSP datapath. Each request carries two 32-bit secondary-register words. A select bit per word picks its low half (bits 15:0) or its high half (bits 31:16) as the 16-bit operand. The block multiplies the two operands as signed, unsigned or mixed-sign numbers. The sign handling depends on the operation and on the halves chosen, and is gated by a held "unsigned" status bit. A second status bit, "keep scale", suppresses the default left shift by one. Without it the product is doubled, as fractional arithmetic needs.

A 2-bit operation code chooses what happens to the 40-bit product register. The product can replace its contents, be added to them, or be subtracted from them. All sums are computed at 40 bits and wrap on overflow. A request is a one-cycle strobe, and the register takes the new value on the clock edge that samples the strobe. The two status bits are written through a separate write strobe.

Top module: `fmul_stage`

## Requirements
- R1: A synchronous reset clears the product register to zero and clears both status bits, so that the default mode is signed and doubled.
- R2: When `cfg_we` is high, the status bits take `cfg_unsigned` and `cfg_keep_scale` at the clock edge. When it is low, they hold their values.
- R3: A select bit of 0 picks bits 15:0 of its source word. A select bit of 1 picks bits 31:16.
- R4: With operation code 00 (cross-register load), unsigned status set and both selects 0, both operands are multiplied as unsigned numbers.
- R5: With operation code 00, unsigned status set and exactly one select 0, the low-half operand is zero-extended and the high-half operand is sign-extended, whichever word supplies the low half.
- R6: In every other case, both operands are sign-extended. This covers operation code 00 with unsigned status clear, code 00 with both selects 1, and codes 01, 10 and 11 at any status.
- R7: The raw product is shifted left by one bit unless the keep-scale status bit is set.
- R8: Operation codes 00 and 01 store the product. Code 10 stores the old register value plus the product. Code 11 stores the old register value minus the product. All results are taken modulo 2^40.
- R9: The product register changes only on the clock edge that samples `req_valid` high, and it holds its value in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Status write strobe |
| cfg_unsigned | input | 1 | New value of the unsigned status bit |
| cfg_keep_scale | input | 1 | New value of the keep-scale (no doubling) status bit |
| src_a | input | 32 | First secondary-register word |
| src_b | input | 32 | Second secondary-register word |
| sel_a | input | 1 | Half select for src_a (0 low, 1 high) |
| sel_b | input | 1 | Half select for src_b (0 low, 1 high) |
| req_valid | input | 1 | One-cycle request strobe |
| req_op | input | 2 | 00 cross load, 01 signed load, 10 add, 11 subtract |
| prod | output | 40 | Product register |
| st_unsigned | output | 1 | Unsigned status bit |
| st_keep_scale | output | 1 | Keep-scale status bit |

## Verification
The in-module assertions check several properties on every cycle: the reset values, that the status bits and the product register hold when there is no strobe, that a doubled load always yields an even value, that an all-unsigned load with scaling kept is never negative, and that a zero operand loads zero. Only the bench's reference model can show the exact values. These are the mixed-sign result for each placement of the low half, and the 40-bit wrap of repeated add and subtract. They also include the interaction of a status write with a request in the same cycle.

// File: rtl/fmul_stage.sv
module fmul_stage #(
  parameter int DW = 16,
  parameter int PW = 40
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic            cfg_unsigned,
  input  logic            cfg_keep_scale,
  input  logic [2*DW-1:0] src_a,
  input  logic [2*DW-1:0] src_b,
  input  logic            sel_a,
  input  logic            sel_b,
  input  logic            req_valid,
  input  logic [1:0]      req_op,
  output logic [PW-1:0]   prod,
  output logic            st_unsigned,
  output logic            st_keep_scale
);
  localparam int EW = DW + 1;
  localparam int MW = 2 * EW;

  // R3 half selection
  logic [DW-1:0] op_a, op_b;
  assign op_a = sel_a ? src_a[2*DW-1:DW] : src_a[DW-1:0];
  assign op_b = sel_b ? src_b[2*DW-1:DW] : src_b[DW-1:0];

  // R4 R5 R6: a low half in a cross load with unsigned status is zero-extended
  logic cross_uns, a_zx, b_zx;
  assign cross_uns = (req_op == 2'b00) && st_unsigned;
  assign a_zx = cross_uns && !sel_a;
  assign b_zx = cross_uns && !sel_b;

  logic signed [EW-1:0] ext_a, ext_b;
  assign ext_a = {(a_zx ? 1'b0 : op_a[DW-1]), op_a};
  assign ext_b = {(b_zx ? 1'b0 : op_b[DW-1]), op_b};

  logic signed [MW-1:0] raw;
  logic signed [PW-1:0] wide, term;
  assign raw  = ext_a * ext_b;
  assign wide = PW'(raw);
  assign term = st_keep_scale ? wide : (wide <<< 1); // R7

  // R8 result selection
  logic [PW-1:0] nxt;
  always_comb begin
    case (req_op)
      2'b10:   nxt = prod + term;
      2'b11:   nxt = prod - term;
      default: nxt = term;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prod          <= '0;
      st_unsigned   <= 1'b0;
      st_keep_scale <= 1'b0;
    end else begin
      if (cfg_we) begin
        st_unsigned   <= cfg_unsigned;
        st_keep_scale <= cfg_keep_scale;
      end
      if (req_valid) prod <= nxt;
    end
  end

  a_r1_reset: assert property (@(posedge clk)
    rst |=> (prod == '0 && !st_unsigned && !st_keep_scale));
  a_r2_status_hold: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable({st_unsigned, st_keep_scale}));
  a_r9_prod_hold: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(prod));
  a_r7_doubled_even: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_op[1] && !st_keep_scale) |=> !prod[0]);
  a_r4_unsigned_nonneg: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 2'b00 && st_unsigned && st_keep_scale && !sel_a && !sel_b)
    |=> !prod[PW-1]);
  a_r3_zero_operand: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_op[1] && op_a == '0) |=> prod == '0);
endmodule

// File: tb/fmul_stage_bench.sv
module fmul_stage_bench;
  logic clk = 0, rst = 1;
  logic cfg_we = 0, cfg_unsigned = 0, cfg_keep_scale = 0;
  logic [31:0] src_a = 0, src_b = 0;
  logic sel_a = 0, sel_b = 0, req_valid = 0;
  logic [1:0] req_op = 0;
  logic [39:0] prod;
  logic st_unsigned, st_keep_scale;

  int total = 0, bad = 0;
  longint m_prod = 0;
  bit m_u = 0, m_k = 0;
  localparam longint MASK = 64'hFF_FFFF_FFFF;

  always #2.5 clk = ~clk;

  fmul_stage u_fmul_stage (.*);

  function automatic longint prodval(logic [31:0] a, logic [31:0] b, bit sa, bit sb,
                                     logic [1:0] op, bit u, bit k);
    logic [15:0] va, vb;
    longint xa, xb, p;
    va = sa ? a[31:16] : a[15:0];   // R3
    vb = sb ? b[31:16] : b[15:0];
    xa = longint'($signed(va));
    xb = longint'($signed(vb));
    if (op == 2'b00 && u) begin     // R4 R5
      if (!sa) xa = longint'(va);
      if (!sb) xb = longint'(vb);
    end
    p = xa * xb;
    if (!k) p = p * 2;              // R7
    return p;
  endfunction

  function automatic string tag_of(logic [1:0] op);
    if (!req_valid) return "R9";
    if (op == 2'b00) return "R5";
    if (op == 2'b01) return "R6";
    return "R8";
  endfunction

  task automatic check(string tag, logic [39:0] act, logic [39:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: update model at the edge, compare at the following falling edge
  task automatic cyc();
    string t;
    @(posedge clk);
    t = tag_of(req_op);
    if (rst) begin
      m_prod = 0; m_u = 0; m_k = 0;
    end else begin
      if (req_valid) begin
        longint p = prodval(src_a, src_b, sel_a, sel_b, req_op, m_u, m_k);
        case (req_op)
          2'b10: m_prod = (m_prod + p) & MASK;
          2'b11: m_prod = (m_prod - p) & MASK;
          default: m_prod = p & MASK;
        endcase
      end
      if (cfg_we) begin m_u = cfg_unsigned; m_k = cfg_keep_scale; end
    end
    @(negedge clk);
    check(rst ? "R1" : t, prod, m_prod[39:0]);
    check("R2", {38'd0, st_unsigned, st_keep_scale}, {38'd0, m_u, m_k});
  endtask

  task automatic setcfg(bit u, bit k);
    cfg_we = 1; cfg_unsigned = u; cfg_keep_scale = k; req_valid = 0;
    cyc();
    cfg_we = 0;
  endtask

  task automatic req(logic [1:0] op, logic [31:0] a, logic [31:0] b, bit sa, bit sb);
    req_valid = 1; req_op = op; src_a = a; src_b = b; sel_a = sa; sel_b = sb;
    cyc();
    req_valid = 0;
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    cyc(); cyc();
    check("R1", {prod, st_unsigned, st_keep_scale}, 42'd0);
    rst = 0;
    // R7 signed doubled default: 0x4000*0x4000*2
    req(2'b01, 32'h0000_4000, 32'h4000_0000, 0, 1);
    check("R7", prod, 40'h0020000000);
    // R4 unsigned, no doubling
    setcfg(1, 1);
    req(2'b00, 32'h1234_FFFF, 32'h8000_FFFF, 0, 0);
    check("R4", prod, 40'h00FFFE0001);
    // R5 mixed, low half from either word
    req(2'b00, 32'h0000_FFFF, 32'hFFFF_0000, 0, 1);
    check("R5", prod, 40'hFFFFFF0001);
    req(2'b00, 32'hFFFF_0000, 32'h0000_FFFF, 1, 0);
    check("R5", prod, 40'hFFFFFF0001);
    // R6 both high stay signed even with unsigned status
    req(2'b00, 32'hFFFF_0000, 32'hFFFF_0000, 1, 1);
    check("R6", prod, 40'h0000000001);
    // R6 signed-load code ignores unsigned status
    req(2'b01, 32'h0000_FFFF, 32'h0000_FFFF, 0, 0);
    check("R6", prod, 40'h0000000001);
    // R8 add and subtract, with wrap
    req(2'b10, 32'h0000_0003, 32'h0000_0004, 0, 0);
    check("R8", prod, 40'h000000000D);
    req(2'b11, 32'h0000_0010, 32'h0000_0001, 0, 0);
    check("R8", prod, 40'hFFFFFFFFFD);
    // R9 hold without strobe
    src_a = 32'h7FFF_7FFF; src_b = 32'h7FFF_7FFF; req_op = 2'b00;
    cyc(); cyc();
    check("R9", prod, 40'hFFFFFFFFFD);
    // R2 status write together with a request uses old status
    cfg_we = 1; cfg_unsigned = 0; cfg_keep_scale = 0;
    req(2'b00, 32'h0000_FFFF, 32'h0000_0002, 0, 0);
    cfg_we = 0;
    check("R2", prod, 40'h000001FFFE);
    // random traffic compared every cycle
    for (int i = 0; i < 3000; i++) begin
      cfg_we = ($urandom % 8) == 0;
      cfg_unsigned = $urandom; cfg_keep_scale = $urandom;
      req_valid = ($urandom % 4) != 0;
      req_op = 2'($urandom);
      src_a = $urandom; src_b = $urandom;
      sel_a = $urandom; sel_b = $urandom;
      rst = ($urandom % 500) == 0;
      cyc();
    end
    rst = 0; req_valid = 0; cfg_we = 0;
    cyc();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule